// File: doc/BRIEF.md
# Bus-Halt Arbiter for Sample and Block-Copy DMA

This block sits between a small CPU core and the shared memory bus. It serves two DMA channels. The first is a single-byte audio-sample fetch, requested by a one-cycle pulse that carries a 16-bit address. The second is a 256-byte block copy, started by a CPU write to a trigger address. The copy reads a page of memory and writes each byte to one fixed destination address.

The arbiter watches the CPU read/write strobe and drives the CPU ready input. It never pulls ready low while the CPU is writing. A free-running two-phase beat splits all cycles into get slots (reads) and put slots (writes), and every DMA access is placed on the matching slot. For a sample fetch, the halt therefore lasts three or four cycles, depending on the slot in which the halt begins. While the CPU is halted, its pending read address stays on the bus. That address is read once more when ready returns.

Top module: `dma_halt_arbiter`

## Requirements
- R1: Ready is never driven low in a cycle where cpu_rw is 0 (write). A pending request waits through any number of CPU writes and halts the CPU in the first read cycle.
- R2: The beat starts on a get slot in the first cycle after reset and then alternates every cycle. Counting cycles from 0 after reset, even cycles are get slots and odd cycles are put slots.
- R3: A sample fetch (bus_addr equal to the latched sample address during a halt) happens only on a get slot, exactly once per request.
- R4: If the halt starts on a get slot, ready stays low for exactly 3 cycles: the halt cycle, an idle cycle, then the fetch.
- R5: If the halt starts on a put slot, ready stays low for exactly 4 cycles, with the fetch in the last of them.
- R6: In every halted cycle that carries no DMA access, and in the cycle ready returns, bus_addr equals cpu_addr with bus_we 0.
- R7: In a CPU write cycle, ready is 1 and the bus carries the CPU address and data with bus_we 1, even while a request is pending.
- R8: A CPU write of page N to TRIG_ADDR starts a copy at the next read cycle. The copy reads {N,k} on get slots and writes that byte to SPR_DST on put slots, for k = 0..255. The halt lasts 514 cycles when it starts on a get slot and 513 when it starts on a put slot.
- R9: A sample request during a copy takes the next get slot. That slot's put slot stays idle. The copy keeps its slot pattern and lasts 2 cycles longer.
- R10: The fetched byte appears on smp_data with smp_valid high for exactly one cycle, the cycle after the fetch. A request that arrives while a sample is already pending and not being fetched is merged into it.
- R11: Ready returns high in the cycle right after the final DMA access of a transfer.
- R12: While reset is held, ready is 1, smp_valid is 0, nothing is pending, and bus_we follows only the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_rw | input | 1 | CPU cycle type: 1 read, 0 write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdy | output | 1 | CPU ready; 0 halts the CPU |
| smp_req | input | 1 | One-cycle sample fetch request |
| smp_addr | input | 16 | Sample fetch address, valid with smp_req |
| smp_valid | output | 1 | One-cycle strobe for smp_data |
| smp_data | output | 8 | Fetched sample byte |
| bus_addr | output | 16 | Memory bus address |
| bus_we | output | 1 | Memory bus write enable |
| bus_wdata | output | 8 | Memory bus write data |
| bus_rdata | input | 8 | Memory bus read data |

## Verification
The assertions take for granted that a halted CPU holds a read (cpu_rw high) until ready returns. They also assume the CPU never writes the trigger address while a copy is pending or running. The bench keeps to this: it drives cpu_rw high with a fixed address for every cycle in which ready is low. It issues triggers only while the arbiter is idle. Sample requests are placed well away from the final write of a copy, so that a new halt cannot start in the release cycle.

// File: rtl/dma_halt_arbiter.sv
module dma_halt_arbiter #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int IW = 8,
  parameter logic [AW-1:0] TRIG_ADDR = 16'h4020,
  parameter logic [AW-1:0] SPR_DST   = 16'h2010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_rw,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_rdy,
  input  logic          smp_req,
  input  logic [AW-1:0] smp_addr,
  output logic          smp_valid,
  output logic [DW-1:0] smp_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  localparam int PW = AW - IW;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_ALIGN, ST_COPY} st_t;

  st_t           st;
  logic          beat;
  logic          smp_pend, spr_pend, spr_have, smp_v;
  logic [AW-1:0] smp_a;
  logic [PW-1:0] page;
  logic [IW-1:0] idx;
  logic [DW-1:0] spr_byte, smp_q;

  wire go        = (st == ST_IDLE) && (smp_pend || spr_pend) && cpu_rw;
  wire get       = !beat;
  wire smp_fetch = get && smp_pend && (st == ST_ALIGN || st == ST_COPY);
  wire spr_rd    = (st == ST_COPY) && get && !smp_pend && !spr_have;
  wire spr_wr    = (st == ST_COPY) && !get && spr_have;
  wire last_wr   = spr_wr && (&idx);

  assign cpu_rdy   = (st == ST_IDLE) && !go;
  wire   trig      = cpu_rdy && !cpu_rw && (cpu_addr == TRIG_ADDR);
  assign bus_addr  = smp_fetch ? smp_a : spr_rd ? {page, idx} : spr_wr ? SPR_DST : cpu_addr;
  assign bus_we    = spr_wr || (cpu_rdy && !cpu_rw);
  assign bus_wdata = spr_wr ? spr_byte : cpu_wdata;
  assign smp_valid = smp_v;
  assign smp_data  = smp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      beat     <= 1'b0;
      smp_pend <= 1'b0;
      spr_pend <= 1'b0;
      spr_have <= 1'b0;
      smp_v    <= 1'b0;
      smp_a    <= '0;
      page     <= '0;
      idx      <= '0;
      spr_byte <= '0;
      smp_q    <= '0;
    end else begin
      beat  <= !beat;
      smp_v <= smp_fetch;
      if (smp_fetch) smp_q <= bus_rdata;

      if (smp_req && (!smp_pend || smp_fetch)) begin
        smp_pend <= 1'b1;
        smp_a    <= smp_addr;
      end else if (smp_fetch) begin
        smp_pend <= 1'b0;
      end

      if (trig) begin
        spr_pend <= 1'b1;
        page     <= PW'(cpu_wdata);
      end

      case (st)
        ST_IDLE: if (go) begin
          idx      <= '0;
          spr_have <= 1'b0;
          if (spr_pend) begin
            st       <= ST_COPY;
            spr_pend <= 1'b0;
          end else begin
            st <= ST_GAP;
          end
        end
        ST_GAP:   st <= ST_ALIGN;
        ST_ALIGN: if (smp_fetch) st <= ST_IDLE;
        ST_COPY: begin
          if (spr_rd) begin
            spr_byte <= bus_rdata;
            spr_have <= 1'b1;
          end
          if (spr_wr) begin
            spr_have <= 1'b0;
            idx      <= idx + 1'b1;
            if (&idx) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  halt_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_rdy) |-> cpu_rw);

  // R3
  smp_get_slot_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> ($past(beat) == 1'b0 && $past(bus_addr) == $past(smp_a) && !$past(bus_we)));

  // R7
  cpu_write_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdy && !cpu_rw) |-> (bus_we && bus_addr == cpu_addr && bus_wdata == cpu_wdata));

  // R8
  copy_put_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !cpu_rdy) |-> (beat && bus_addr == SPR_DST));

  // R11
  release_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $past(last_wr) |-> (st == ST_IDLE));

endmodule

// File: tb/dma_halt_arbiter_bench.sv
`timescale 1ns/1ps
module dma_halt_arbiter_bench;
  localparam logic [15:0] TRIG = 16'h4020;
  localparam logic [15:0] DST  = 16'h2010;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cpu_rw = 1'b1, smp_req = 1'b0;
  logic [15:0] cpu_addr = 16'h0500, smp_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_rdy, smp_valid, bus_we;
  logic [7:0]  smp_data, bus_wdata, bus_rdata;
  logic [15:0] bus_addr;
  int errs = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign bus_rdata = pat(bus_addr);

  dma_halt_arbiter u_dma_halt_arbiter (
    .clk(clk), .rst(rst), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdy(cpu_rdy), .smp_req(smp_req), .smp_addr(smp_addr), .smp_valid(smp_valid),
    .smp_data(smp_data), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step;
    @(posedge clk);
    cyc++;
    #0.5;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic do_sample(input int w, input logic [15:0] a);
    int low, exp_len, fetch_at, seen;
    cpu_rw = 1'b1; cpu_addr = 16'h0500; smp_req = 1'b1; smp_addr = a;
    #0.5; step;
    smp_req = 1'b0;
    for (int i = 0; i < w; i++) begin
      cpu_rw = 1'b0; cpu_addr = 16'h0600 + 16'(i); cpu_wdata = 8'h11 + 8'(i);
      #0.5;
      chk(cpu_rdy === 1'b1, "R1 ready held high in write", cpu_rdy, 1);
      chk(bus_we === 1'b1 && bus_addr === cpu_addr && bus_wdata === cpu_wdata,
          "R7 write passes", bus_addr, cpu_addr);
      step;
    end
    cpu_rw = 1'b1; cpu_addr = 16'h0700;
    #0.5;
    chk(cpu_rdy === 1'b0, "R1 halt at first read", cpu_rdy, 0);
    exp_len = (cyc % 2 == 0) ? 3 : 4;
    low = 0; seen = 0; fetch_at = 0;
    while (cpu_rdy === 1'b0 && low < 10) begin
      low++;
      if (bus_addr === a) begin
        seen++; fetch_at = low;
        chk(cyc % 2 == 0, "R2 R3 fetch on get slot", cyc % 2, 0);
      end else begin
        chk(bus_addr === 16'h0700 && bus_we === 1'b0, "R6 cpu address held", bus_addr, 16'h0700);
      end
      step;
    end
    if (exp_len == 3) chk(low == 3, "R4 halt length", low, 3);
    else              chk(low == 4, "R5 halt length", low, 4);
    chk(seen == 1, "R3 single fetch", seen, 1);
    chk(fetch_at == low, "R11 release after fetch", fetch_at, low);
    chk(cpu_rdy === 1'b1 && bus_addr === 16'h0700, "R6 repeat read after release", bus_addr, 16'h0700);
    chk(smp_valid === 1'b1 && smp_data === pat(a), "R10 sample data", smp_data, pat(a));
    step;
    chk(smp_valid === 1'b0, "R10 valid one cycle", smp_valid, 0);
  endtask

  task automatic do_merge;
    int low, seen;
    cpu_rw = 1'b1; cpu_addr = 16'h0500; smp_req = 1'b1; smp_addr = 16'hC700;
    #0.5; step;
    smp_addr = 16'hC7F0;
    #0.5;
    low = 0; seen = 0;
    while (cpu_rdy === 1'b0 && low < 10) begin
      low++;
      smp_req = 1'b0;
      if (bus_addr === 16'hC700) seen++;
      chk(bus_addr !== 16'hC7F0, "R10 merged request not fetched", bus_addr, 16'hC700);
      step;
    end
    smp_req = 1'b0;
    chk(seen == 1, "R10 merged fetch count", seen, 1);
    for (int i = 0; i < 6; i++) begin
      chk(cpu_rdy === 1'b1, "R10 no second halt after merge", cpu_rdy, 1);
      step;
    end
  endtask

  task automatic do_copy(input logic [7:0] pg, input int inj);
    int low, exp_len, k, rk, sf;
    cpu_rw = 1'b0; cpu_addr = TRIG; cpu_wdata = pg;
    #0.5;
    chk(cpu_rdy === 1'b1 && bus_we === 1'b1, "R7 trigger write passes", cpu_rdy, 1);
    step;
    cpu_rw = 1'b1; cpu_addr = 16'h0800;
    #0.5;
    chk(cpu_rdy === 1'b0, "R8 copy starts at next read", cpu_rdy, 0);
    exp_len = ((cyc % 2 == 0) ? 514 : 513) + ((inj >= 0) ? 2 : 0);
    low = 0; k = 0; rk = 0; sf = 0;
    while (cpu_rdy === 1'b0 && low < 1000) begin
      low++;
      if (low == inj) begin smp_req = 1'b1; smp_addr = 16'hD055; end
      else smp_req = 1'b0;
      if (smp_valid === 1'b1)
        chk(smp_data === pat(16'hD055), "R9 R10 interleaved data", smp_data, pat(16'hD055));
      if (bus_we === 1'b1) begin
        chk(bus_addr === DST && cyc % 2 == 1 && bus_wdata === pat({pg, 8'(k)}),
            "R8 copy write", bus_wdata, pat({pg, 8'(k)}));
        k++;
      end else if (bus_addr === 16'hD055) begin
        sf++;
        chk(cyc % 2 == 0, "R9 sample on get slot", cyc % 2, 0);
      end else if (bus_addr === {pg, 8'(rk)}) begin
        chk(cyc % 2 == 0, "R2 R8 copy read on get slot", cyc % 2, 0);
        rk++;
      end else begin
        chk(bus_addr === 16'h0800, "R6 cpu address during copy", bus_addr, 16'h0800);
      end
      step;
    end
    smp_req = 1'b0;
    if (inj >= 0) chk(low == exp_len, "R9 copy length with sample", low, exp_len);
    else          chk(low == exp_len, "R8 copy length", low, exp_len);
    chk(k == 256 && rk == 256, "R8 byte count", k, 256);
    chk(sf == ((inj >= 0) ? 1 : 0), "R9 sample fetch count", sf, (inj >= 0) ? 1 : 0);
    chk(cpu_rdy === 1'b1 && bus_addr === 16'h0800, "R11 release after last write", cpu_rdy, 1);
  endtask

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    chk(cpu_rdy === 1'b1 && smp_valid === 1'b0 && bus_we === 1'b0, "R12 reset state", cpu_rdy, 1);
    cpu_rw = 1'b0; cpu_addr = 16'h0333;
    #0.5;
    chk(bus_we === 1'b1 && cpu_rdy === 1'b1, "R12 reset write passes", bus_we, 1);
    cpu_rw = 1'b1;
    rst = 1'b0;
    cyc = 0;
    step;
    for (int w = 0; w < 4; w++)
      for (int off = 0; off < 2; off++) begin
        if (off == 1) step;
        do_sample(w, 16'hC000 + 16'(w * 16 + off));
      end
    do_merge();
    do_copy(8'h3C, -1);
    step;
    do_copy(8'hA1, 100);
    do_copy(8'h57, 301);
    report();
  end
endmodule